// File: doc/BRIEF.md
# Segmented DAC Switch-Control Front End

This block is the clocked digital path in front of an 8-bit segmented current-steering converter. It splits each input word into two parts. The upper (coarse) bits select how many identical unit current cells are switched on, and this count is sent out as a thermometer code. The lower (fine) bits are passed on unchanged as binary controls for a weighted ladder that divides the current of one unit cell. Because the unit cells are identical and switch on in order, each step between adjacent codes changes the output by one ladder step, including across the coarse boundary.

Both parts are registered on the falling clock edge. A first stage holds the decoded thermometer lines and a delayed copy of the fine bits. A second stage then re-registers all twelve switch controls together, so that every control from one input word changes on the same edge. This limits the output glitch that skewed switching would cause. The controls hold their value until a new word has passed through. A behavioural code output rebuilds the converter's ideal code from the registered controls, so that the mapping can be checked.

Top module: `seg_dac_front`

## Requirements
- R1: Bits [7:5] of `code_in` are the coarse value and bits [4:0] are the fine value.
- R2: `unit_en[k]` is 1 exactly when the coarse value is greater than k, for k = 0..6. The set lines are therefore contiguous from bit 0, and no set line has a clear line below it.
- R3: `fine_en` equals the fine value of the same input word, with bit i carrying the weight 2^i of one unit cell.
- R4: Words are captured only on falling clock edges. The controls reflect the word sampled at the falling edge two falling edges earlier.
- R5: All twelve controls for one word appear on the same falling edge. Across the 31 to 32 step, `unit_en` goes from 0 to 0000001 while `fine_en` goes from 31 to 0, on one edge and with no mixed state.
- R6: While `code_in` is held constant, all outputs stay constant.
- R7: When `rst_n` is low at a falling edge, both stages clear. `unit_en`, `fine_en` and `code_mon` all read 0 afterwards.
- R8: `code_mon` equals (number of set `unit_en` lines) × 32 + `fine_en`. For each of the 256 codes it equals the input word captured two edges earlier, so the mapping is monotonic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its falling edge |
| rst_n | input | 1 | Active-low synchronous clear |
| code_in | input | 8 | Input word: coarse bits [7:5], fine bits [4:0] |
| unit_en | output | 7 | Thermometer enables, one per unit current cell |
| fine_en | output | 5 | Binary controls for the weighted ladder |
| code_mon | output | 8 | Ideal code rebuilt from the registered controls |

## Verification
On every falling edge, the assertions check the following: the set thermometer lines are contiguous; the number of set unit lines and the fine controls both match the word captured two edges earlier; and the outputs stay frozen while the input is held. The bench's reference queue covers the full code sweep, the 31 to 32 step, the reset values and a reset in the middle of a run. This shows together that every code maps to itself, that both control groups move on one edge, and that clearing takes effect at the next falling edge.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
   // number of set bits in a vector of up to 64 bits
   function automatic int unsigned ones_in(input logic [63:0] v);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 64; i++) n += int'(v[i]);
      return n;
   endfunction
endpackage

// File: rtl/seg_dac_therm.sv
module seg_dac_therm #(
   parameter int COARSE_W = 3,
   localparam int UNITS   = (1 << COARSE_W) - 1
) (
   input  logic [COARSE_W-1:0] coarse,
   output logic [UNITS-1:0]    therm
);
   for (genvar k = 0; k < UNITS; k++) begin : g_line
      localparam logic [COARSE_W-1:0] LEVEL = COARSE_W'(k);
      assign therm[k] = (coarse > LEVEL);
   end
endmodule

// File: rtl/seg_dac_negreg.sv
module seg_dac_negreg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(negedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/seg_dac_codemon.sv
module seg_dac_codemon #(
   parameter int COARSE_W = 3,
   parameter int FINE_W   = 5,
   localparam int UNITS   = (1 << COARSE_W) - 1
) (
   input  logic [UNITS-1:0]           unit,
   input  logic [FINE_W-1:0]          fine,
   output logic [COARSE_W+FINE_W-1:0] code
);
   logic [COARSE_W-1:0] n;
   always_comb begin
      n = '0;
      for (int i = 0; i < UNITS; i++) n = n + COARSE_W'(unit[i]);
      code = {n, fine};
   end
endmodule

// File: rtl/seg_dac_front.sv
module seg_dac_front #(
   parameter int COARSE_W = 3,
   parameter int FINE_W   = 5
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [COARSE_W+FINE_W-1:0]   code_in,
   output logic [(1<<COARSE_W)-2:0]     unit_en,
   output logic [FINE_W-1:0]            fine_en,
   output logic [COARSE_W+FINE_W-1:0]   code_mon
);
   localparam int UNITS  = (1 << COARSE_W) - 1;
   localparam int CTRL_W = UNITS + FINE_W;

   if (COARSE_W < 1 || COARSE_W > 6) begin : g_bad_coarse
      $error("COARSE_W out of range");
   end
   if (FINE_W < 1) begin : g_bad_fine
      $error("FINE_W must be positive");
   end

   logic [UNITS-1:0]  therm_d;
   logic [CTRL_W-1:0] st1_q;
   logic [CTRL_W-1:0] st2_q;

   seg_dac_therm #(.COARSE_W(COARSE_W)) u_therm (
      .coarse (code_in[COARSE_W+FINE_W-1:FINE_W]),
      .therm  (therm_d)
   );

   // stage 1: decoded unit lines plus delayed fine bits
   seg_dac_negreg #(.W(CTRL_W)) u_st1 (
      .clk (clk), .rst_n (rst_n),
      .d   ({therm_d, code_in[FINE_W-1:0]}),
      .q   (st1_q)
   );

   // stage 2: all switch controls re-registered together
   seg_dac_negreg #(.W(CTRL_W)) u_st2 (
      .clk (clk), .rst_n (rst_n),
      .d   (st1_q),
      .q   (st2_q)
   );

   assign unit_en = st2_q[CTRL_W-1:FINE_W];
   assign fine_en = st2_q[FINE_W-1:0];

   seg_dac_codemon #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_mon (
      .unit (unit_en),
      .fine (fine_en),
      .code (code_mon)
   );
endmodule

// File: rtl/seg_dac_front_chk.sv
module seg_dac_front_chk #(
   parameter int COARSE_W = 3,
   parameter int FINE_W   = 5,
   localparam int UNITS   = (1 << COARSE_W) - 1,
   localparam int DW      = COARSE_W + FINE_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DW-1:0]    code_in,
   input logic [UNITS-1:0] unit_en,
   input logic [FINE_W-1:0] fine_en,
   input logic [DW-1:0]    code_mon
);
   logic [1:0] since_rst;
   always_ff @(negedge clk) begin
      if (!rst_n)              since_rst <= '0;
      else if (since_rst != 3) since_rst <= since_rst + 2'd1;
   end

   AST_THERM_CONTIG: assert property (@(negedge clk) disable iff (!rst_n)
      (unit_en & (unit_en + UNITS'(1))) == '0); // R2

   AST_UNIT_COUNT: assert property (@(negedge clk) disable iff (!rst_n)
      (since_rst >= 2) |-> ($countones(unit_en) == int'($past(code_in[DW-1:FINE_W], 2)))); // R4

   AST_FINE_PASS: assert property (@(negedge clk) disable iff (!rst_n)
      (since_rst >= 2) |-> (fine_en == $past(code_in[FINE_W-1:0], 2))); // R3

   AST_HOLD_STEADY: assert property (@(negedge clk) disable iff (!rst_n)
      (since_rst == 3 && $past(code_in) == $past(code_in, 2) && $past(code_in, 2) == $past(code_in, 3))
      |-> ($stable(unit_en) && $stable(fine_en) && $stable(code_mon))); // R6
endmodule

bind seg_dac_front seg_dac_front_chk #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_chk (
   .clk (clk), .rst_n (rst_n), .code_in (code_in),
   .unit_en (unit_en), .fine_en (fine_en), .code_mon (code_mon)
);

// File: tb/test_seg_dac_front.sv
module test_seg_dac_front;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] code_in = '0;
   logic [6:0] unit_en;
   logic [4:0] fine_en;
   logic [7:0] code_mon;

   int total = 0;
   int bad   = 0;
   int exp_code = 0;
   int hist[$];

   always #(CLK_P/2) clk = ~clk;

   seg_dac_front i_seg_dac_front (
      .clk (clk), .rst_n (rst_n), .code_in (code_in),
      .unit_en (unit_en), .fine_en (fine_en), .code_mon (code_mon)
   );

   // reference: queue of words sampled at falling edges
   always @(negedge clk) begin
      if (!rst_n) begin
         hist.delete();
         exp_code = 0;
      end else begin
         hist.push_back(int'(code_in));
         if (hist.size() > 2) void'(hist.pop_front());
         exp_code = (hist.size() == 2) ? hist[0] : 0;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int therm_of(input int c);
      int t;
      t = 0;
      for (int k = 0; k < 7; k++) if ((c >> 5) > k) t |= (1 << k);
      return t;
   endfunction

   // compare all outputs with the model, after the falling edge has settled
   task automatic step(input int nxt);
      @(posedge clk); #1;
      chk("R2 unit_en", int'(unit_en), therm_of(exp_code));
      chk("R3 fine_en", int'(fine_en), exp_code & 31);
      chk("R8 code_mon", int'(code_mon), exp_code);
      code_in = 8'(nxt);
   endtask

   initial begin
      #(CLK_P * 100000);
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int p_u, p_f, p_m;
      code_in = 8'hFF;
      repeat (3) @(posedge clk);
      #1;
      // R7: reset clears everything even with a nonzero input
      chk("R7 unit_en", int'(unit_en), 0);
      chk("R7 fine_en", int'(fine_en), 0);
      chk("R7 code_mon", int'(code_mon), 0);
      rst_n = 1'b1;
      code_in = 8'd0;

      // R1 R8: full sweep of all codes, model compared every cycle
      for (int c = 1; c < 256; c++) step(c);
      step(8'h3C); step(8'h3C); step(8'h3C);

      // R4: one falling edge after a new word the old controls remain
      code_in = 8'hC7;
      @(posedge clk); #1;
      chk("R4 latency one edge", int'(code_mon), 8'h3C);
      @(posedge clk); #1;
      chk("R4 latency two edges", int'(code_mon), 8'hC7);

      // R6: hold the word, outputs frozen
      p_u = int'(unit_en); p_f = int'(fine_en); p_m = int'(code_mon);
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); #1;
         chk("R6 hold unit", int'(unit_en), p_u);
         chk("R6 hold fine", int'(fine_en), p_f);
         chk("R6 hold mon", int'(code_mon), p_m);
      end

      // R5: major step 31 -> 32
      code_in = 8'd31;
      repeat (3) @(posedge clk);
      #1;
      chk("R5 before unit", int'(unit_en), 0);
      chk("R5 before fine", int'(fine_en), 31);
      code_in = 8'd32;
      @(posedge clk); #1;
      chk("R5 one edge unit", int'(unit_en), 0);
      chk("R5 one edge fine", int'(fine_en), 31);
      @(posedge clk); #1;
      chk("R5 after unit", int'(unit_en), 1);
      chk("R5 after fine", int'(fine_en), 0);

      // descending pattern across segment boundaries
      for (int c = 255; c >= 0; c -= 17) step(c);
      step(8'd224); step(8'd223); step(8'd96); step(8'd95);

      // R7: mid-run reset
      code_in = 8'hE9;
      repeat (2) @(posedge clk);
      #1;
      rst_n = 1'b0;
      @(posedge clk); #1;
      chk("R7 mid-run unit", int'(unit_en), 0);
      chk("R7 mid-run fine", int'(fine_en), 0);
      chk("R7 mid-run mon", int'(code_mon), 0);
      rst_n = 1'b1;
      step(8'h81); step(8'h81); step(8'h81);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule